// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit performs one bit-shift or bit-rotate operation per cycle on an 8-bit or 16-bit operand. Seven operations are offered: logical left, logical right, arithmetic right, plain rotate left and right, and rotate left and right through the carry flag. In the through-carry forms the carry acts as one extra ring position, so the ring is 9 bits wide in byte mode and 17 bits wide in word mode. The step count is either a fixed one or the value of an 8-bit count input.

Alongside the result, the unit produces the next state of the carry, overflow, zero, sign and parity flags. It takes the incoming values of those flags, so it can leave any of them unchanged where the operation has no effect on them. Inputs are captured on a valid strobe and the result and flags appear in registers one clock later.

Top module: `shrot_unit`

## Requirements
- R1: Op code 0 (logical left) moves bits toward the top, fills bit 0 with zero, and the carry holds the last bit shifted out of the top; byte 0xCB by one gives 0x96 with carry 1; counts above the width give zero and carry 0.
- R2: Op code 1 (logical right) fills the top bit with zero, and the carry holds the last bit shifted out of bit 0; byte 0xCB by one gives 0x65 with carry 1.
- R3: Op code 2 (arithmetic right) keeps the sign bit in place on every step, and the carry holds the last bit shifted out of bit 0; byte 0xCB by one gives 0xE5 with carry 1; counts of the width or more give all sign bits, with the carry equal to the sign.
- R4: Op codes 3 and 4 (plain rotate left and right) move the top bit into bit 0 or bit 0 into the top; the count is taken modulo the width, and the carry equals result bit 0 after a left rotate and the top result bit after a right rotate.
- R5: Op codes 5 and 6 (rotate left and right through carry) rotate the operand and the carry as one ring of width plus one bits; on a left step the carry enters bit 0 and the old top bit becomes the carry, and a right step does the mirror image.
- R6: When count_from_reg is 0 the step count is one, whatever cnt_reg holds; when it is 1 the step count is cnt_reg.
- R7: A step count of zero leaves the result equal to the operand and every output flag equal to its incoming value.
- R8: With a step count of exactly one, overflow is the exclusive-or of the operand's top bit and the result's top bit; with a count of two or more it is 0.
- R9: After a nonzero shift (op codes 0 to 2), zero flags a result of zero, sign copies the result's top bit, and parity is 1 when result bits 7:0 hold an even number of ones; rotates pass the incoming zero, sign and parity flags through.
- R10: wide_sel 0 selects byte mode on operand bits 7:0, with result bits 15:8 forced to zero and the top bit at position 7; wide_sel 1 selects word mode on all 16 bits.
- R11: Op code 7 is a pass-through: the result is the operand and all flags keep their incoming values.
- R12: Results and flags are registered and appear one cycle after in_valid; out_valid follows in_valid by one cycle, and a synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture the operation this cycle |
| op_sel | input | 3 | Operation code (0 to 7) |
| wide_sel | input | 1 | 1 for word mode, 0 for byte mode |
| count_from_reg | input | 1 | 1 takes the count from cnt_reg, 0 uses one |
| cnt_reg | input | 8 | Count register value |
| operand | input | 16 | Value to shift or rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| pf_in | input | 1 | Incoming parity flag |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | Outgoing carry flag |
| of_out | output | 1 | Outgoing overflow flag |
| zf_out | output | 1 | Outgoing zero flag |
| sf_out | output | 1 | Outgoing sign flag |
| pf_out | output | 1 | Outgoing parity flag |

## Verification
Some properties are checked on every cycle: the one-cycle valid timing, the zero-count and pass-through hold of the operand and flags, the cleared upper byte in byte mode, the forced-low overflow for multi-step counts, and the untouched zero, sign and parity flags across rotates. The actual bit movement of each operation cannot be stated as a cycle property without copying the datapath. For that the bench relies on a step-by-step model that walks every requested step literally, including counts far beyond the width and through-carry rings wrapping several times. The bench also uses the fixed byte example and random mixes of mode, count source and flags.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_PASS = 3'd7
  } shrot_op_e;

  function automatic logic op_is_shift(shrot_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction

  function automatic logic op_is_rotate(shrot_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

  // even number of ones gives 1
  function automatic logic even_par8(logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/shrot_count_norm.sv
module shrot_count_norm
  import shrot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  localparam int STEP_W = $clog2(W + 2)
) (
  input  shrot_op_e         op,
  input  logic [CNT_W-1:0]  cnt,
  output logic [STEP_W-1:0] steps
);

  localparam logic [CNT_W-1:0] LIM_SHIFT = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] MOD_ROT   = CNT_W'(W);
  localparam logic [CNT_W-1:0] MOD_RING  = CNT_W'(W + 1);

  logic [CNT_W-1:0] reduced;

  always_comb begin
    case (op)
      OP_SHL, OP_SHR, OP_SAR: reduced = (cnt > LIM_SHIFT) ? LIM_SHIFT : cnt;
      OP_ROL, OP_ROR:         reduced = cnt % MOD_ROT;
      OP_RCL, OP_RCR:         reduced = cnt % MOD_RING;
      default:                reduced = '0;
    endcase
    steps = STEP_W'(reduced);
  end

endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  localparam int STEP_W = $clog2(W + 2)
) (
  input  shrot_op_e        op,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     val,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);

  logic [STEP_W-1:0] steps;

  shrot_count_norm #(.W(W), .CNT_W(CNT_W)) u_norm (
    .op    (op),
    .cnt   (cnt),
    .steps (steps)
  );

  logic [W-1:0] v;
  logic         c;
  logic         nc;

  always_comb begin
    v  = val;
    c  = cin;
    nc = 1'b0;
    for (int i = 0; i < W + 1; i++) begin
      if (i < int'(steps)) begin
        case (op)
          OP_SHL: begin c = v[W-1]; v = {v[W-2:0], 1'b0};   end
          OP_SHR: begin c = v[0];   v = {1'b0, v[W-1:1]};   end
          OP_SAR: begin c = v[0];   v = {v[W-1], v[W-1:1]}; end
          OP_ROL: begin c = v[W-1]; v = {v[W-2:0], v[W-1]}; end
          OP_ROR: begin c = v[0];   v = {v[0], v[W-1:1]};   end
          OP_RCL: begin nc = v[W-1]; v = {v[W-2:0], c}; c = nc; end
          OP_RCR: begin nc = v[0];   v = {c, v[W-1:1]}; c = nc; end
          default: begin v = v; c = c; end
        endcase
      end
    end
    res = v;
    // plain rotates: carry is the bit that landed at the far end, even
    // when the reduced count wraps to zero
    case (op)
      OP_ROL:  cout = v[0];
      OP_ROR:  cout = v[W-1];
      default: cout = c;
    endcase
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  shrot_op_e  op,
  input  logic       raw_zero,
  input  logic       count_one,
  input  logic       old_msb,
  input  logic       new_msb,
  input  logic       res_zero,
  input  logic [7:0] res_low8,
  input  logic       core_cf,
  input  logic       cf_in,
  input  logic       of_in,
  input  logic       zf_in,
  input  logic       sf_in,
  input  logic       pf_in,
  output logic       cf_nx,
  output logic       of_nx,
  output logic       zf_nx,
  output logic       sf_nx,
  output logic       pf_nx
);

  logic hold_all;

  always_comb begin
    hold_all = raw_zero || (op == OP_PASS);
    if (hold_all) begin
      cf_nx = cf_in;
      of_nx = of_in;
      zf_nx = zf_in;
      sf_nx = sf_in;
      pf_nx = pf_in;
    end else begin
      cf_nx = core_cf;
      of_nx = count_one ? (old_msb ^ new_msb) : 1'b0;
      if (op_is_shift(op)) begin
        zf_nx = res_zero;
        sf_nx = new_msb;
        pf_nx = even_par8(res_low8);
      end else begin
        zf_nx = zf_in;
        sf_nx = sf_in;
        pf_nx = pf_in;
      end
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic              wide_sel,
  input  logic              count_from_reg,
  input  logic [CNT_W-1:0]  cnt_reg,
  input  logic [WIDE_W-1:0] operand,
  input  logic              cf_in,
  input  logic              of_in,
  input  logic              zf_in,
  input  logic              sf_in,
  input  logic              pf_in,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic              cf_out,
  output logic              of_out,
  output logic              zf_out,
  output logic              sf_out,
  output logic              pf_out
);

  localparam int LANES = 2;

  shrot_op_e        op;
  logic [CNT_W-1:0] raw_cnt;
  logic             raw_zero;
  logic             count_one;

  assign op        = shrot_op_e'(op_sel);
  assign raw_cnt   = count_from_reg ? cnt_reg : CNT_W'(1);
  assign raw_zero  = (raw_cnt == '0);
  assign count_one = (raw_cnt == CNT_W'(1));

  logic [WIDE_W-1:0] lane_res  [LANES];
  logic              lane_cf   [LANES];
  logic              lane_omsb [LANES];
  logic              lane_nmsb [LANES];
  logic              lane_zero [LANES];

  // lane 0 is byte mode, lane 1 is word mode
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] l_res;
    logic          l_cf;

    shrot_core #(.W(LW), .CNT_W(CNT_W)) u_core (
      .op   (op),
      .cnt  (raw_cnt),
      .val  (operand[LW-1:0]),
      .cin  (cf_in),
      .res  (l_res),
      .cout (l_cf)
    );

    assign lane_res[g]  = WIDE_W'(l_res);
    assign lane_cf[g]   = l_cf;
    assign lane_omsb[g] = operand[LW-1];
    assign lane_nmsb[g] = l_res[LW-1];
    assign lane_zero[g] = (l_res == '0);
  end

  logic [WIDE_W-1:0] sel_res;
  logic [WIDE_W-1:0] in_masked;
  logic [WIDE_W-1:0] res_nx;
  logic              cf_nx, of_nx, zf_nx, sf_nx, pf_nx;

  assign sel_res   = wide_sel ? lane_res[1] : lane_res[0];
  assign in_masked = wide_sel ? operand : WIDE_W'(operand[NARROW_W-1:0]);
  assign res_nx    = (raw_zero || op == OP_PASS) ? in_masked : sel_res;

  shrot_flags u_flags (
    .op        (op),
    .raw_zero  (raw_zero),
    .count_one (count_one),
    .old_msb   (wide_sel ? lane_omsb[1] : lane_omsb[0]),
    .new_msb   (wide_sel ? lane_nmsb[1] : lane_nmsb[0]),
    .res_zero  (wide_sel ? lane_zero[1] : lane_zero[0]),
    .res_low8  (sel_res[7:0]),
    .core_cf   (wide_sel ? lane_cf[1] : lane_cf[0]),
    .cf_in     (cf_in),
    .of_in     (of_in),
    .zf_in     (zf_in),
    .sf_in     (sf_in),
    .pf_in     (pf_in),
    .cf_nx     (cf_nx),
    .of_nx     (of_nx),
    .zf_nx     (zf_nx),
    .sf_nx     (sf_nx),
    .pf_nx     (pf_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cf_out    <= 1'b0;
      of_out    <= 1'b0;
      zf_out    <= 1'b0;
      sf_out    <= 1'b0;
      pf_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_nx;
        cf_out <= cf_nx;
        of_out <= of_nx;
        zf_out <= zf_nx;
        sf_out <= sf_nx;
        pf_out <= pf_nx;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R12
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count_from_reg && cnt_reg == '0)
      |=> (result == $past(in_masked) && cf_out == $past(cf_in)
           && of_out == $past(of_in))); // R7
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd7)
      |=> (result == $past(in_masked) && zf_out == $past(zf_in))); // R11
  AST_MULTI_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 3'd7 && count_from_reg && cnt_reg > CNT_W'(1))
      |=> !of_out); // R8
  AST_ROT_KEEPS_ZSP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_rotate(op))
      |=> (zf_out == $past(zf_in) && sf_out == $past(sf_in)
           && pf_out == $past(pf_in))); // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> (result[WIDE_W-1:NARROW_W] == '0)); // R10

endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

  typedef struct packed {
    logic [15:0] r;
    logic c, o, z, s, p;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        wide_sel = 1'b0;
  logic        count_from_reg = 1'b0;
  logic [7:0]  cnt_reg = '0;
  logic [15:0] operand = '0;
  logic        cf_in = 0, of_in = 0, zf_in = 0, sf_in = 0, pf_in = 0;
  logic        out_valid;
  logic [15:0] result;
  logic        cf_out, of_out, zf_out, sf_out, pf_out;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .wide_sel(wide_sel), .count_from_reg(count_from_reg), .cnt_reg(cnt_reg),
    .operand(operand), .cf_in(cf_in), .of_in(of_in), .zf_in(zf_in),
    .sf_in(sf_in), .pf_in(pf_in), .out_valid(out_valid), .result(result),
    .cf_out(cf_out), .of_out(of_out), .zf_out(zf_out), .sf_out(sf_out),
    .pf_out(pf_out)
  );

  // step-by-step model, walks every requested step
  function automatic exp_t model(logic [2:0] op, logic wide, logic usecl,
                                 logic [7:0] cnt, logic [15:0] val,
                                 logic ci, logic oi, logic zi, logic si, logic pi);
    exp_t e;
    int w = wide ? 16 : 8;
    int n = usecl ? int'(cnt) : 1;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    logic [15:0] v = val & mask;
    logic c = ci;
    logic msb, lsb, oldtop;
    oldtop = v[w-1];
    if (op == 3'd7 || n == 0) begin
      e = '{r: v, c: ci, o: oi, z: zi, s: si, p: pi};
      return e;
    end
    for (int k = 0; k < n; k++) begin
      msb = v[w-1];
      lsb = v[0];
      case (op)
        3'd0: begin c = msb; v = (v << 1) & mask; end
        3'd1: begin c = lsb; v = v >> 1; end
        3'd2: begin c = lsb; v = (v >> 1) | (16'(msb) << (w-1)); end
        3'd3: begin c = msb; v = ((v << 1) & mask) | 16'(msb); end
        3'd4: begin c = lsb; v = (v >> 1) | (16'(lsb) << (w-1)); end
        3'd5: begin v = ((v << 1) & mask) | 16'(c); c = msb; end
        default: begin v = (v >> 1) | (16'(c) << (w-1)); c = lsb; end
      endcase
    end
    e.r = v;
    e.c = c;
    e.o = (n == 1) ? (oldtop ^ v[w-1]) : 1'b0;
    if (op <= 3'd2) begin
      e.z = (v == 16'h0);
      e.s = v[w-1];
      e.p = ~(^v[7:0]);
    end else begin
      e.z = zi; e.s = si; e.p = pi;
    end
    return e;
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic send(logic [2:0] op, logic wide, logic usecl, logic [7:0] cnt,
                      logic [15:0] val, logic [4:0] fl, string tag);
    @(negedge clk);
    op_sel = op; wide_sel = wide; count_from_reg = usecl; cnt_reg = cnt;
    operand = val;
    {cf_in, of_in, zf_in, sf_in, pf_in} = fl;
    in_valid = 1'b1;
    exp_q.push_back(model(op, wide, usecl, cnt, val, fl[4], fl[3], fl[2], fl[1], fl[0]));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      exp_t got;
      string t;
      checks++;
      got = '{r: result, c: cf_out, o: of_out, z: zf_out, s: sf_out, p: pf_out};
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R12: unexpected out_valid, got res=%h", result);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          errs++;
          $display("FAIL %s: got res=%h c%0b o%0b z%0b s%0b p%0b expected res=%h c%0b o%0b z%0b s%0b p%0b",
                   t, got.r, got.c, got.o, got.z, got.s, got.p,
                   e.r, e.c, e.o, e.z, e.s, e.p);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    // R12 reset state
    if (out_valid !== 1'b0 || result !== 16'h0 ||
        {cf_out, of_out, zf_out, sf_out, pf_out} !== 5'b0) begin
      errs++;
      $display("FAIL R12: reset state got v=%0b res=%h expected v=0 res=0000", out_valid, result);
    end
    @(negedge clk);
    rst = 1'b0;

    // fixed byte example 0xCB, single step
    send(3'd0, 0, 0, 8'd0, 16'h00CB, 5'b0, "R1");
    send(3'd1, 0, 0, 8'd0, 16'h00CB, 5'b0, "R2");
    send(3'd2, 0, 0, 8'd0, 16'h00CB, 5'b0, "R3");
    // wide shifts beyond width
    send(3'd0, 1, 1, 8'd16, 16'h8001, 5'b0, "R1");
    send(3'd0, 1, 1, 8'd17, 16'hFFFF, 5'b10000, "R1");
    send(3'd2, 1, 1, 8'd40, 16'h8000, 5'b0, "R3");
    send(3'd2, 0, 1, 8'd255, 16'h0040, 5'b10000, "R3");
    // plain rotate wrapping counts
    send(3'd3, 0, 1, 8'd8, 16'h0081, 5'b0, "R4");
    send(3'd4, 1, 1, 8'd35, 16'h1234, 5'b0, "R4");
    // through-carry rings
    send(3'd5, 0, 1, 8'd9, 16'h00A5, 5'b10000, "R5");
    send(3'd5, 1, 1, 8'd1, 16'h8000, 5'b10000, "R5");
    send(3'd6, 1, 1, 8'd18, 16'h0001, 5'b00000, "R5");
    send(3'd6, 0, 1, 8'd4, 16'h003C, 5'b10000, "R5");
    // count source select ignores cnt_reg
    send(3'd0, 1, 0, 8'd7, 16'h4001, 5'b0, "R6");
    send(3'd1, 0, 0, 8'd200, 16'h0002, 5'b0, "R6");
    // zero count holds everything
    send(3'd0, 1, 1, 8'd0, 16'hBEEF, 5'b10101, "R7");
    send(3'd5, 0, 1, 8'd0, 16'h12F0, 5'b01010, "R7");
    // overflow single vs multi
    send(3'd0, 0, 0, 8'd0, 16'h0040, 5'b0, "R8");
    send(3'd0, 0, 1, 8'd2, 16'h0020, 5'b01000, "R8");
    // flags on shift vs rotate
    send(3'd1, 0, 0, 8'd0, 16'h0001, 5'b0, "R9");
    send(3'd3, 1, 1, 8'd3, 16'h0000, 5'b00111, "R9");
    // byte mode upper bits ignored and cleared
    send(3'd3, 0, 0, 8'd0, 16'hFF80, 5'b0, "R10");
    // pass-through op
    send(3'd7, 1, 1, 8'd5, 16'hCAFE, 5'b11011, "R11");
    idle(1);
    // back-to-back after a bubble, then no-valid check
    send(3'd2, 1, 0, 8'd0, 16'h8001, 5'b0, "R12");
    idle(3);
    checks++;
    if (out_valid !== 1'b0) begin
      errs++;
      $display("FAIL R12: out_valid got %0b expected 0 while idle", out_valid);
    end

    for (int i = 0; i < 1500; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [7:0] c  = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 255))
                                                   : 8'($urandom_range(0, 40));
      send(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), c,
           16'($urandom), 5'($urandom), op_tag(op));
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL R12: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule